// File: doc/BRIEF.md
# Debug Address/Data Watchpoint Unit

This unit observes the processor's memory access bus and raises a halt request when a programmed access is seen. It has two comparator resources. Each has an enable, a two-bit access-kind select and a value/mask pair. In independent mode the two comparators act as two separate address watchpoints. In paired mode comparator 0 matches the address and comparator 1 matches the data, so together they form one watchpoint that needs both matches.

Read data returns a fixed number of cycles after its address. For paired reads, the unit carries each address hit down a short alignment pipeline. It then tests the returning read data in the cycle that hit reaches the end of the pipeline. Once a watchpoint resolves, the unit does not halt at once. It counts instruction-retire pulses and asserts the halt request only after a set number of them. That number depends on the kind of watchpoint. The halt request and the status flags stay set until a clear pulse.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset, `halt_req` is 0 and `hit_flags` is 2'b00.
- R2: A comparator address match holds when `((bus_addr ^ value) & mask) == 0`. A mask bit of 1 means that address bit is compared, and a mask bit of 0 means it is ignored.
- R3: The kind select works as follows: bit 0 set lets the comparator match reads (`bus_rd`), and bit 1 set lets it match writes (`bus_wr`). A comparator whose enable is 0, or whose kind is 2'b00, never matches.
- R4: In independent mode (`cfg_pair_mode`=0), flag bit 0 identifies comparator 0 and flag bit 1 identifies comparator 1. If both comparators hit the same access, both flags are set.
- R5: Retire pulses are counted only in cycles after the access cycle. An address-only read hit asserts `halt_req` in the cycle after the 3rd retire pulse.
- R6: An address write hit asserts `halt_req` in the cycle after the 6th retire pulse that follows the access cycle.
- R7: In paired mode, a read whose address hits comparator 0 has its data checked on `bus_rdata` exactly RD_LAT (default 3) cycles after the access, against comparator 1's value and mask. If that data matches, `halt_req` asserts after the 6th retire pulse counted from the access, including retires during the wait. Otherwise no halt occurs.
- R8: In paired mode, a write needs both a comparator 0 address hit and a match of `bus_wdata` against comparator 1 in the same cycle. Such a write halts after 6 retire pulses. A write whose data does not match never halts.
- R9: `halt_req` and `hit_flags` hold until `halt_clr` is pulsed. Both then read 0 in the next cycle.
- R10: A match that resolves while a countdown is pending, or while a halt is held, is ignored. It neither changes the flags nor re-arms after the clear.
- R11: In paired mode, the only watchpoint is the one reporting flags 2'b01. Comparator 1 never fires as an address watchpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pair_mode | input | 1 | 1: comparators form one address+data watchpoint |
| cmp0_en | input | 1 | Comparator 0 enable |
| cmp0_kind | input | 2 | Comparator 0 access select (bit0 read, bit1 write) |
| cmp0_value | input | BUS_W | Comparator 0 address value |
| cmp0_mask | input | BUS_W | Comparator 0 compare mask |
| cmp1_en | input | 1 | Comparator 1 enable (independent mode) |
| cmp1_kind | input | 2 | Comparator 1 access select (independent mode) |
| cmp1_value | input | BUS_W | Comparator 1 address value, or data value in paired mode |
| cmp1_mask | input | BUS_W | Comparator 1 compare mask |
| bus_addr | input | BUS_W | Access address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | input | BUS_W | Read data, valid RD_LAT cycles after the read |
| bus_wdata | input | BUS_W | Write data, valid with the write strobe |
| retire | input | 1 | One-cycle pulse per retired instruction |
| halt_clr | input | 1 | Clears the halt request and the flags |
| halt_req | output | 1 | Halt request to the processor |
| hit_flags | output | 2 | Which watchpoint fired |

## Verification
The bench aims at off-by-one retire counting. A design that counts the retire in the access cycle, or that misses retires falling inside the read-data wait, halts one instruction early or late. The bench also sends read data one cycle too early and mismatched data. A pairing that is misaligned would either halt on these or miss the real match. Two further cases are mask and kind filtering, where a wrong bit test fires on a filtered access, and a second hit during a pending countdown, which a design lacking the lockout would let overwrite the flags or re-arm after the clear.

// File: rtl/dbgw_pkg.sv
// Package: shared encodings for the watchpoint unit.
// Assumes: kind select bit 0 enables reads, bit 1 enables writes.
package dbgw_pkg;
    localparam int KIND_RD_BIT = 0;
    localparam int KIND_WR_BIT = 1;

    // Which source armed the halt timer in a given cycle.
    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_IND     = 2'd1,
        SRC_PAIR_WR = 2'd2,
        SRC_PAIR_RD = 2'd3
    } arm_src_e;

    localparam logic [1:0] FLAG_WP0 = 2'b01;
endpackage

// File: rtl/masked_match.sv
// Module: masked equality test.
// Assumes: a mask bit of 1 takes part in the compare.
module masked_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] probe,
    output logic         eq
);
    // Compare only the bits selected by the mask.
    always_comb eq = (((probe ^ value) & mask) == '0);
endmodule

// File: rtl/wp_comparator.sv
// Module: one address comparator qualified by enable and access kind.
// Assumes: read and write strobes are single-cycle and not both set.
module wp_comparator
    import dbgw_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         en,
    input  logic [1:0]   kind,
    input  logic [W-1:0] value,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] addr,
    input  logic         rd,
    input  logic         wr,
    output logic         hit_rd,
    output logic         hit_wr
);
    logic addr_eq;

    masked_match #(.W(W)) u_match (
        .value (value),
        .mask  (mask),
        .probe (addr),
        .eq    (addr_eq)
    );

    // Qualify the address match with enable, kind and strobe.
    always_comb begin
        hit_rd = en & kind[KIND_RD_BIT] & rd & addr_eq;
        hit_wr = en & kind[KIND_WR_BIT] & wr & addr_eq;
    end
endmodule

// File: rtl/rd_align_pipe.sv
// Module: carries a read address hit down DEPTH stages so it meets
// its read data, counting retire pulses seen on the way.
// Assumes: DEPTH >= 1; the counts are zero in empty stages.
module rd_align_pipe #(
    parameter int DEPTH = 3,
    parameter int EW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          retire,
    output logic          out_valid,
    output logic [EW-1:0] out_elapsed
);
    logic [DEPTH-1:0] stg_v;
    logic [EW-1:0]    stg_e [DEPTH];

    // Stage 0 captures the new hit with nothing elapsed yet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v[0] <= 1'b0;
            stg_e[0] <= '0;
        end else begin
            stg_v[0] <= push;
            stg_e[0] <= '0;
        end
    end

    generate
        for (genvar s = 1; s < DEPTH; s++) begin : g_stage
            // Shift one stage, adding this cycle's retire to a live entry.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_v[s] <= 1'b0;
                    stg_e[s] <= '0;
                end else begin
                    stg_v[s] <= stg_v[s-1];
                    stg_e[s] <= stg_v[s-1] ? stg_e[s-1] + EW'(retire) : '0;
                end
            end
        end
    endgenerate

    // Present the oldest stage.
    always_comb begin
        out_valid   = stg_v[DEPTH-1];
        out_elapsed = stg_e[DEPTH-1];
    end

    AST_PIPE_ELAPSED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_elapsed <= EW'(DEPTH - 1))); // R7
    AST_PIPE_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_elapsed == '0)); // R7
endmodule

// File: rtl/halt_timer.sv
// Module: counts retire pulses after an arm and then holds the halt.
// Assumes: arm_flags is non-zero whenever arm is set.
module halt_timer #(
    parameter int CW = 3,
    parameter int FW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [CW-1:0] arm_count,
    input  logic [FW-1:0] arm_flags,
    input  logic          retire,
    input  logic          clr,
    output logic          halt,
    output logic [FW-1:0] flags,
    output logic          blocked
);
    logic          pend;
    logic [CW-1:0] cnt;
    logic [FW-1:0] pflags;

    // Arm, count down on retires, and latch the halt until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            cnt    <= '0;
            pflags <= '0;
            halt   <= 1'b0;
            flags  <= '0;
        end else if (clr) begin
            pend   <= 1'b0;
            cnt    <= '0;
            pflags <= '0;
            halt   <= 1'b0;
            flags  <= '0;
        end else if (!pend && !halt && arm) begin
            if (arm_count == '0) begin
                halt  <= 1'b1;
                flags <= arm_flags;
            end else begin
                pend   <= 1'b1;
                cnt    <= arm_count;
                pflags <= arm_flags;
            end
        end else if (pend && retire) begin
            if (cnt == CW'(1)) begin
                pend  <= 1'b0;
                cnt   <= '0;
                halt  <= 1'b1;
                flags <= pflags;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    // New arms are refused while counting or halted.
    always_comb blocked = pend | halt;

    AST_HALT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr) |=> (halt && $stable(flags))); // R9
    AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!halt && flags == '0)); // R9
    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> ($past(retire) || $past(arm))); // R5
    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr && !retire) |=> (pend && $stable(cnt) && $stable(pflags))); // R10
    AST_FLAGS_WITH_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (flags != '0)); // R4
    AST_PEND_NOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend && halt)); // R10
endmodule

// File: rtl/dbg_watch_unit.sv
// Module: debug watchpoint unit top. Two comparators act as two address
// watchpoints or as one address+data watchpoint; the chosen one arms a
// retire-counting timer that raises a held halt request.
// Assumes: RD_LAT >= 1; bus_rdata is valid RD_LAT cycles after bus_rd.
module dbg_watch_unit
    import dbgw_pkg::*;
#(
    parameter int BUS_W        = 16,
    parameter int RD_LAT       = 3,
    parameter int RD_ADDR_HALT = 3,
    parameter int RD_DATA_HALT = 6,
    parameter int WR_HALT      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_pair_mode,
    input  logic             cmp0_en,
    input  logic [1:0]       cmp0_kind,
    input  logic [BUS_W-1:0] cmp0_value,
    input  logic [BUS_W-1:0] cmp0_mask,
    input  logic             cmp1_en,
    input  logic [1:0]       cmp1_kind,
    input  logic [BUS_W-1:0] cmp1_value,
    input  logic [BUS_W-1:0] cmp1_mask,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_rdata,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             retire,
    input  logic             halt_clr,
    output logic             halt_req,
    output logic [1:0]       hit_flags
);
    localparam int MAX_HALT = (RD_DATA_HALT > WR_HALT)
                            ? ((RD_DATA_HALT > RD_ADDR_HALT) ? RD_DATA_HALT : RD_ADDR_HALT)
                            : ((WR_HALT > RD_ADDR_HALT) ? WR_HALT : RD_ADDR_HALT);
    localparam int CW = $clog2(MAX_HALT + 1);
    localparam int EW = $clog2(RD_LAT + 1);
    localparam int NCMP = 2;

    logic             c_en   [NCMP];
    logic [1:0]       c_kind [NCMP];
    logic [BUS_W-1:0] c_val  [NCMP];
    logic [BUS_W-1:0] c_msk  [NCMP];
    logic [NCMP-1:0]  hit_rd;
    logic [NCMP-1:0]  hit_wr;

    // Gather the per-comparator settings into arrays.
    always_comb begin
        c_en[0]   = cmp0_en;
        c_kind[0] = cmp0_kind;
        c_val[0]  = cmp0_value;
        c_msk[0]  = cmp0_mask;
        c_en[1]   = cmp1_en;
        c_kind[1] = cmp1_kind;
        c_val[1]  = cmp1_value;
        c_msk[1]  = cmp1_mask;
    end

    generate
        for (genvar g = 0; g < NCMP; g++) begin : g_cmp
            wp_comparator #(.W(BUS_W)) u_cmp (
                .en     (c_en[g]),
                .kind   (c_kind[g]),
                .value  (c_val[g]),
                .mask   (c_msk[g]),
                .addr   (bus_addr),
                .rd     (bus_rd),
                .wr     (bus_wr),
                .hit_rd (hit_rd[g]),
                .hit_wr (hit_wr[g])
            );
        end
    endgenerate

    // Data matches against comparator 1 for the paired watchpoint.
    logic rdata_eq;
    logic wdata_eq;

    masked_match #(.W(BUS_W)) u_rdata_match (
        .value (cmp1_value),
        .mask  (cmp1_mask),
        .probe (bus_rdata),
        .eq    (rdata_eq)
    );

    masked_match #(.W(BUS_W)) u_wdata_match (
        .value (cmp1_value),
        .mask  (cmp1_mask),
        .probe (bus_wdata),
        .eq    (wdata_eq)
    );

    // Read-address hits in paired mode wait for their data.
    logic          pipe_push;
    logic          pipe_v;
    logic [EW-1:0] pipe_e;

    always_comb pipe_push = cfg_pair_mode & hit_rd[0];

    rd_align_pipe #(.DEPTH(RD_LAT), .EW(EW)) u_align (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (pipe_push),
        .retire      (retire),
        .out_valid   (pipe_v),
        .out_elapsed (pipe_e)
    );

    // Independent-mode watchpoint decode.
    logic       ind_hit0;
    logic       ind_hit1;
    logic       ind_any_wr;
    logic [1:0] ind_flags;

    always_comb begin
        ind_hit0   = !cfg_pair_mode & (hit_rd[0] | hit_wr[0]);
        ind_hit1   = !cfg_pair_mode & (hit_rd[1] | hit_wr[1]);
        ind_any_wr = !cfg_pair_mode & (hit_wr[0] | hit_wr[1]);
        ind_flags  = {ind_hit1, ind_hit0};
    end

    // Paired-mode resolution and the retires still owed after data arrives.
    logic          pair_wr_hit;
    logic          pair_rd_hit;
    logic [EW:0]   rd_seen;
    logic [CW-1:0] rd_left;

    always_comb begin
        pair_wr_hit = cfg_pair_mode & hit_wr[0] & wdata_eq;
        pair_rd_hit = cfg_pair_mode & pipe_v & rdata_eq;
        rd_seen     = {1'b0, pipe_e} + (EW+1)'(retire);
        if (int'(rd_seen) >= RD_DATA_HALT) rd_left = '0;
        else                               rd_left = CW'(RD_DATA_HALT - int'(rd_seen));
    end

    // Pick one arm source; the oldest access (a resolving read) goes first.
    arm_src_e      src;
    logic          arm;
    logic [CW-1:0] arm_count;
    logic [1:0]    arm_flags;

    always_comb begin
        if (pair_rd_hit)                 src = SRC_PAIR_RD;
        else if (pair_wr_hit)            src = SRC_PAIR_WR;
        else if (ind_hit0 | ind_hit1)    src = SRC_IND;
        else                             src = SRC_NONE;
        arm = (src != SRC_NONE);
        unique case (src)
            SRC_PAIR_RD: begin
                arm_count = rd_left;
                arm_flags = FLAG_WP0;
            end
            SRC_PAIR_WR: begin
                arm_count = CW'(WR_HALT);
                arm_flags = FLAG_WP0;
            end
            SRC_IND: begin
                arm_count = ind_any_wr ? CW'(WR_HALT) : CW'(RD_ADDR_HALT);
                arm_flags = ind_flags;
            end
            default: begin
                arm_count = '0;
                arm_flags = '0;
            end
        endcase
    end

    logic timer_blocked;

    halt_timer #(.CW(CW), .FW(2)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .arm_count (arm_count),
        .arm_flags (arm_flags),
        .retire    (retire),
        .clr       (halt_clr),
        .halt      (halt_req),
        .flags     (hit_flags),
        .blocked   (timer_blocked)
    );

    AST_PAIR_SINGLE_WP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pair_mode && arm) |-> (arm_flags == FLAG_WP0)); // R11
    AST_BLOCKED_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_blocked && halt_req && !halt_clr) |=> $stable(hit_flags)); // R10
    AST_PAIR_DATA_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pair_mode && !pipe_v && !hit_wr[0]) |-> !arm); // R7
endmodule

// File: tb/dbg_watch_unit_tb.sv
`timescale 1ns/1ps
module dbg_watch_unit_tb;
    localparam int W      = 16;
    localparam int RD_LAT = 3;
    localparam logic [1:0] K_NONE = 2'b00;
    localparam logic [1:0] K_RD   = 2'b01;
    localparam logic [1:0] K_WR   = 2'b10;
    localparam logic [1:0] K_ANY  = 2'b11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_pair_mode = 1'b0;
    logic         cmp0_en = 1'b0;
    logic [1:0]   cmp0_kind = 2'b00;
    logic [W-1:0] cmp0_value = '0;
    logic [W-1:0] cmp0_mask = '0;
    logic         cmp1_en = 1'b0;
    logic [1:0]   cmp1_kind = 2'b00;
    logic [W-1:0] cmp1_value = '0;
    logic [W-1:0] cmp1_mask = '0;
    logic [W-1:0] bus_addr = '0;
    logic         bus_rd = 1'b0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_rdata = '0;
    logic [W-1:0] bus_wdata = '0;
    logic         retire = 1'b0;
    logic         halt_clr = 1'b0;
    logic         halt_req;
    logic [1:0]   hit_flags;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dbg_watch_unit #(.BUS_W(W), .RD_LAT(RD_LAT)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_pair_mode (cfg_pair_mode),
        .cmp0_en       (cmp0_en),
        .cmp0_kind     (cmp0_kind),
        .cmp0_value    (cmp0_value),
        .cmp0_mask     (cmp0_mask),
        .cmp1_en       (cmp1_en),
        .cmp1_kind     (cmp1_kind),
        .cmp1_value    (cmp1_value),
        .cmp1_mask     (cmp1_mask),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_rdata     (bus_rdata),
        .bus_wdata     (bus_wdata),
        .retire        (retire),
        .halt_clr      (halt_clr),
        .halt_req      (halt_req),
        .hit_flags     (hit_flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, return at the next falling edge.
    task automatic tick(input logic rd, input logic wr, input logic [W-1:0] a,
                        input logic [W-1:0] wd, input logic [W-1:0] rdat,
                        input logic ret, input logic clr);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        bus_rdata = rdat; retire = ret; halt_clr = clr;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; retire = 1'b0; halt_clr = 1'b0;
        bus_rdata = '0; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, '0, '0, '0, 0, 0);
    endtask

    task automatic rets(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, '0, '0, '0, 1, 0);
    endtask

    task automatic clear();
        tick(0, 0, '0, '0, '0, 0, 1);
    endtask

    task automatic cfg(input logic pair,
                       input logic e0, input logic [1:0] k0, input logic [W-1:0] v0, input logic [W-1:0] m0,
                       input logic e1, input logic [1:0] k1, input logic [W-1:0] v1, input logic [W-1:0] m1);
        cfg_pair_mode = pair;
        cmp0_en = e0; cmp0_kind = k0; cmp0_value = v0; cmp0_mask = m0;
        cmp1_en = e1; cmp1_kind = k1; cmp1_value = v1; cmp1_mask = m1;
    endtask

    task automatic t_reset();
        chk("R1 halt after reset", 32'(halt_req), 32'd0);
        chk("R1 flags after reset", 32'(hit_flags), 32'd0);
    endtask

    task automatic t_read_addr();
        cfg(0, 1, K_RD, 16'h1000, 16'hFFFF, 0, K_NONE, '0, '0);
        tick(1, 0, 16'h1000, '0, '0, 1, 0);   // retire in the access cycle is not counted
        rets(2);
        chk("R5 no halt after 2 retires", 32'(halt_req), 32'd0);
        idle(2);
        chk("R5 no halt without retires", 32'(halt_req), 32'd0);
        rets(1);
        chk("R5 halt after 3rd retire", 32'(halt_req), 32'd1);
        chk("R4 flags comparator 0", 32'(hit_flags), 32'h1);
        idle(3);
        chk("R9 halt held", 32'(halt_req), 32'd1);
        clear();
        chk("R9 halt cleared", 32'(halt_req), 32'd0);
        chk("R9 flags cleared", 32'(hit_flags), 32'd0);
    endtask

    task automatic t_write_mask();
        cfg(0, 0, K_NONE, '0, '0, 1, K_WR, 16'h1230, 16'hFFF0);
        tick(0, 1, 16'h1237, 16'h0, '0, 0, 0);
        rets(5);
        chk("R6 no halt after 5 retires", 32'(halt_req), 32'd0);
        rets(1);
        chk("R6 halt after 6th retire", 32'(halt_req), 32'd1);
        chk("R4 R2 flags comparator 1", 32'(hit_flags), 32'h2);
        clear();
    endtask

    task automatic t_kind_filter();
        cfg(0, 1, K_WR, 16'h2000, 16'hFFFF, 0, K_NONE, '0, '0);
        tick(1, 0, 16'h2000, '0, '0, 0, 0);
        rets(8);
        chk("R3 read ignored by write-only", 32'(halt_req), 32'd0);
        cfg(0, 0, K_ANY, 16'h2000, 16'hFFFF, 0, K_NONE, '0, '0);
        tick(0, 1, 16'h2000, '0, '0, 0, 0);
        rets(8);
        chk("R3 disabled comparator", 32'(halt_req), 32'd0);
        cfg(0, 1, K_NONE, 16'h2000, 16'hFFFF, 0, K_NONE, '0, '0);
        tick(0, 1, 16'h2000, '0, '0, 0, 0);
        rets(8);
        chk("R3 kind 00 never matches", 32'(halt_req), 32'd0);
    endtask

    task automatic t_mask();
        cfg(0, 1, K_RD, 16'h1230, 16'hFFF0, 0, K_NONE, '0, '0);
        tick(1, 0, 16'h1270, '0, '0, 0, 0);
        rets(8);
        chk("R2 compared bit differs", 32'(halt_req), 32'd0);
        tick(1, 0, 16'h123F, '0, '0, 0, 0);
        rets(3);
        chk("R2 masked bits ignored", 32'(halt_req), 32'd1);
        clear();
    endtask

    task automatic t_both();
        cfg(0, 1, K_ANY, 16'h3000, 16'hFFFF, 1, K_ANY, 16'h30AA, 16'hFF00);
        tick(1, 0, 16'h3000, '0, '0, 0, 0);
        rets(3);
        chk("R4 both comparators halt", 32'(halt_req), 32'd1);
        chk("R4 both flags", 32'(hit_flags), 32'h3);
        clear();
    endtask

    task automatic t_pair_read();
        cfg(1, 1, K_RD, 16'h4000, 16'hFFFF, 0, K_NONE, 16'hBEEF, 16'hFFFF);
        tick(1, 0, 16'h4000, '0, '0, 0, 0);   // access cycle t
        tick(0, 0, '0, '0, '0, 0, 0);         // t+1
        tick(0, 0, '0, '0, '0, 1, 0);         // t+2: retire counts
        tick(0, 0, '0, '0, 16'hBEEF, 0, 0);   // t+3: data
        chk("R7 no halt at data", 32'(halt_req), 32'd0);
        rets(4);
        chk("R7 no halt after 5 retires", 32'(halt_req), 32'd0);
        rets(1);
        chk("R7 halt after 6 retires", 32'(halt_req), 32'd1);
        chk("R7 R11 paired flag", 32'(hit_flags), 32'h1);
        clear();
        tick(1, 0, 16'h4000, '0, '0, 0, 0);
        tick(0, 0, '0, '0, '0, 1, 0);
        tick(0, 0, '0, '0, '0, 1, 0);
        tick(0, 0, '0, '0, 16'hBEEF, 1, 0);   // retire in data cycle counts
        rets(2);
        chk("R7 no halt after 5 (retire in data cycle)", 32'(halt_req), 32'd0);
        rets(1);
        chk("R7 halt after 6 (retire in data cycle)", 32'(halt_req), 32'd1);
        clear();
    endtask

    task automatic t_pair_read_miss();
        cfg(1, 1, K_RD, 16'h4000, 16'hFFFF, 0, K_NONE, 16'hBEEF, 16'hFFFF);
        tick(1, 0, 16'h4000, '0, '0, 0, 0);
        idle(2);
        tick(0, 0, '0, '0, 16'hBEEE, 0, 0);
        rets(8);
        chk("R7 data mismatch no halt", 32'(halt_req), 32'd0);
        tick(1, 0, 16'h4000, '0, '0, 0, 0);
        idle(1);
        tick(0, 0, '0, '0, 16'hBEEF, 0, 0);   // one cycle early
        tick(0, 0, '0, '0, 16'h0000, 0, 0);
        rets(8);
        chk("R7 early data no halt", 32'(halt_req), 32'd0);
    endtask

    task automatic t_pair_write();
        cfg(1, 1, K_WR, 16'h5000, 16'hFFFF, 0, K_NONE, 16'hBEEF, 16'hFFFF);
        tick(0, 1, 16'h5000, 16'hBEEF, '0, 0, 0);
        rets(5);
        chk("R8 no halt after 5", 32'(halt_req), 32'd0);
        rets(1);
        chk("R8 halt after 6", 32'(halt_req), 32'd1);
        chk("R8 paired flag", 32'(hit_flags), 32'h1);
        clear();
        tick(0, 1, 16'h5000, 16'h0EEF, '0, 0, 0);
        rets(8);
        chk("R8 wdata mismatch no halt", 32'(halt_req), 32'd0);
    endtask

    task automatic t_pair_no_cmp1_addr();
        cfg(1, 1, K_RD, 16'h6000, 16'hFFFF, 1, K_ANY, 16'h7000, 16'hFFFF);
        tick(1, 0, 16'h7000, '0, '0, 0, 0);
        idle(2);
        tick(0, 0, '0, '0, 16'h7000, 0, 0);
        rets(8);
        chk("R11 comparator 1 not an address watchpoint", 32'(halt_req), 32'd0);
    endtask

    task automatic t_pending_ignore();
        cfg(0, 1, K_RD, 16'h8000, 16'hFFFF, 1, K_WR, 16'h9000, 16'hFFFF);
        tick(1, 0, 16'h8000, '0, '0, 0, 0);
        rets(1);
        tick(0, 1, 16'h9000, '0, '0, 0, 0);   // hit while pending
        rets(1);
        chk("R10 still pending", 32'(halt_req), 32'd0);
        rets(1);
        chk("R10 first watchpoint timing kept", 32'(halt_req), 32'd1);
        chk("R10 first watchpoint flags kept", 32'(hit_flags), 32'h1);
        tick(0, 1, 16'h9000, '0, '0, 0, 0);   // hit while halted
        rets(8);
        chk("R10 flags unchanged while halted", 32'(hit_flags), 32'h1);
        clear();
        rets(8);
        chk("R10 nothing re-armed after clear", 32'(halt_req), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_addr();
        t_write_mask();
        t_kind_filter();
        t_mask();
        t_both();
        t_pair_read();
        t_pair_read_miss();
        t_pair_write();
        t_pair_no_cmp1_addr();
        t_pending_ignore();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule